// File: doc/BRIEF.md
# Multi-mode 16-bit timer peripheral

This block is a 16-bit timer that a processor drives through a byte-wide register port. Two 16-bit compare/period registers (R1, R2), a 16-bit capture register and two control bytes (A and B) sit behind a 5-bit register address. Writes happen on a clock edge with the write strobe high. Reads are combinational from the address. Control byte B selects one of four modes and the capture edge polarity. In the two counting modes it also picks a power-of-two prescaler.

In PWM mode the output pin is high for R1 ticks and then low for R2 ticks, over and over. The prescaler sets the tick. In event mode the same waveform engine advances once per synchronized rising edge of an external clock pin. In capture mode the counter runs free on prescaled ticks. An active edge on the first capture pin copies the counter into the capture register. An active edge on the second capture pin copies it into R2. Edges set flags in control byte A, and a level interrupt request combines those flags with enable bits.

Top module: `mtimer16`

## Requirements
- R1: After reset every register reads 0x00, `pwm_out` is low and `irq` is low.
- R2: Read addresses: 0/1 capture low/high, 2/3 R2 low/high, 4/5 R1 low/high, 6 control B, 7 control A. Write addresses: 0x12/0x13 R2 low/high, 0x14/0x15 R1 low/high, 0x16 control B, 0x17 control A. Control A keeps only bits 7,6,5,4,2 and control B keeps only bits 6,4:0; the other bits read 0. Any other read address returns 0x00.
- R3: A write strobe at any address other than 0x10 and 0x12 to 0x17 changes no register.
- R4: Control B bits 1:0 = 01 selects PWM mode. After a counter clear, `pwm_out` is high for R1 ticks, then low for R2 ticks, and repeats. A length of 0 acts as 1.
- R5: Control B bits 4:2 hold PS. Ticks occur every 2^PS clocks, the first one 2^PS clocks after the clear write's edge.
- R6: A write to address 0x10 zeroes the counter and the prescaler and restarts the waveform at the start of its high interval.
- R7: Control B bits 1:0 = 10 selects capture mode, in which the counter increments once per tick. An active edge on `cap1_in` loads the counter into the capture register and sets control A bit 6. An active edge on `cap2_in` loads the counter into R2 and sets bit 7. Each pin passes through two synchronizer flops, so the load happens on the third clock edge after the pin changes, with the counter value present just before that edge.
- R8: Control B bit 6 = 1 makes rising edges active on the capture pins; 0 makes falling edges active. Edges of the other direction are ignored.
- R9: Control B bits 1:0 = 11 selects event mode. The PWM waveform of R4 then advances once per synchronized rising edge of `ext_in`, three edges after the pin rises, and the prescaler has no effect.
- R10: Control A bit 4 sets on the tick that ends each low interval in PWM and event modes.
- R11: A write to control A replaces its flag bits with the written bits, so writing 0x00 clears all pending flags.
- R12: `irq` is high exactly when (bit 6 or bit 7) and bit 5 of control A are set, or when bits 4 and 2 are both set.
- R13: With control B bits 1:0 = 00, the counter and waveform hold, capture pins are ignored and `pwm_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register address for reads and writes |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for `bus_addr` (combinational) |
| cap1_in | input | 1 | Capture pin 1 (loads the capture register) |
| cap2_in | input | 1 | Capture pin 2 (loads R2) |
| ext_in | input | 1 | External count pin for event mode |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | Level interrupt request |

## Verification
A register write is visible on the read port from the clock edge that samples it. Waveform steps and the compare flag appear on the edge of the tick that causes them. The tick count after n clocks from the clear edge is n >> PS. A capture or external-pin edge takes effect on the third clock edge after the pin changes. The bench drives and samples on the falling clock edge, counts rising edges from the clear write, and derives each expected output from those counts. Result checks are delayed by at least the stated latency.

// File: rtl/mtimer16_pkg.sv
package mtimer16_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int PS_W   = 3;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'b00,
        MD_PWM   = 2'b01,
        MD_CAPT  = 2'b10,
        MD_EVENT = 2'b11
    } mode_e;

    // read side
    localparam logic [ADDR_W-1:0] RD_CAP_LO = 5'h00;
    localparam logic [ADDR_W-1:0] RD_CAP_HI = 5'h01;
    localparam logic [ADDR_W-1:0] RD_R2_LO  = 5'h02;
    localparam logic [ADDR_W-1:0] RD_R2_HI  = 5'h03;
    localparam logic [ADDR_W-1:0] RD_R1_LO  = 5'h04;
    localparam logic [ADDR_W-1:0] RD_R1_HI  = 5'h05;
    localparam logic [ADDR_W-1:0] RD_CTLB   = 5'h06;
    localparam logic [ADDR_W-1:0] RD_CTLA   = 5'h07;
    // write side
    localparam logic [ADDR_W-1:0] WR_CLEAR  = 5'h10;
    localparam logic [ADDR_W-1:0] WR_R2_LO  = 5'h12;
    localparam logic [ADDR_W-1:0] WR_R2_HI  = 5'h13;
    localparam logic [ADDR_W-1:0] WR_R1_LO  = 5'h14;
    localparam logic [ADDR_W-1:0] WR_R1_HI  = 5'h15;
    localparam logic [ADDR_W-1:0] WR_CTLB   = 5'h16;
    localparam logic [ADDR_W-1:0] WR_CTLA   = 5'h17;

    // control A bit positions
    localparam int A_CMP_IE = 2;
    localparam int A_CMP_F  = 4;
    localparam int A_CAP_IE = 5;
    localparam int A_CAP1_F = 6;
    localparam int A_CAP2_F = 7;
    // control B bit positions
    localparam int B_PS_LO  = 2;
    localparam int B_POL    = 6;

    localparam logic [BYTE_W-1:0] A_KEEP = 8'hF4;
    localparam logic [BYTE_W-1:0] B_KEEP = 8'h5F;
endpackage

// File: rtl/mtimer16_sync.sv
module mtimer16_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] now_o,
    output logic [N-1:0] was_o
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        typedef struct packed {
            logic s1;
            logic s2;
            logic was;
        } sync_t;
        sync_t st_d, st_q;

        always_comb begin
            st_d.s1  = pin_i[i];
            st_d.s2  = st_q.s1;
            st_d.was = st_q.s2;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign now_o[i] = st_q.s2;
        assign was_o[i] = st_q.was;

        // a detected rising edge never repeats on the next cycle (R7, R9)
        p_edge_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.s2 && !st_q.was) |=> !(st_q.s2 && !st_q.was));
    end
endmodule

// File: rtl/mtimer16_presc.sv
module mtimer16_presc #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int PRE_W = (1 << PS_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask  = (PRE_W'(1) << ps) - PRE_W'(1);
        tick  = ((pre_q & mask) == mask);
        pre_d = clr ? '0 : pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // clear realigns the divider (R5, R6)
    p_presc_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));
endmodule

// File: rtl/mtimer16_seq.sv
module mtimer16_seq
    import mtimer16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  mode_e        mode,
    input  logic [W-1:0] len_hi,
    input  logic [W-1:0] len_lo,
    output logic [W-1:0] cnt,
    output logic         phase_hi,
    output logic         low_done
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         phase_hi;
    } seq_t;

    seq_t st_d, st_q;
    logic [W-1:0] len, len_eff;
    logic [W:0]   nxt;
    logic         last;

    always_comb begin
        st_d     = st_q;
        low_done = 1'b0;
        len      = st_q.phase_hi ? len_hi : len_lo;
        len_eff  = (len == '0) ? W'(1) : len;
        nxt      = {1'b0, st_q.cnt} + (W+1)'(1);
        last     = (nxt >= {1'b0, len_eff});
        if (clr) begin
            st_d.cnt      = '0;
            st_d.phase_hi = 1'b1;
        end else if (adv) begin
            case (mode)
                MD_CAPT: st_d.cnt = nxt[W-1:0];
                MD_PWM, MD_EVENT: begin
                    if (last) begin
                        st_d.cnt      = '0;
                        st_d.phase_hi = !st_q.phase_hi;
                        low_done      = !st_q.phase_hi;
                    end else begin
                        st_d.cnt = nxt[W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, phase_hi: 1'b1};
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign phase_hi = st_q.phase_hi;

    p_clear_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && st_q.phase_hi));
    p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv || clr) |=> $stable(st_q.phase_hi));
    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_IDLE && !clr) |=> $stable(st_q));
endmodule

// File: rtl/mtimer16.sv
module mtimer16
    import mtimer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cap1_in,
    input  logic              cap2_in,
    input  logic              ext_in,
    output logic              pwm_out,
    output logic              irq
);
    localparam int N_PINS   = 3;
    localparam int PIN_CAP1 = 0;
    localparam int PIN_CAP2 = 1;
    localparam int PIN_EXT  = 2;

    typedef struct packed {
        logic [CNT_W-1:0]  cap;
        logic [CNT_W-1:0]  r1;
        logic [CNT_W-1:0]  r2;
        logic [BYTE_W-1:0] ctla;
        logic [BYTE_W-1:0] ctlb;
    } regs_t;

    regs_t r_d, r_q;

    logic [N_PINS-1:0] pin_now, pin_was, pin_rise;
    logic [1:0]        cap_fall, cap_edge;
    mode_e             mode;
    logic              clr_hit, wr_a, wr_reg;
    logic              presc_tick, adv;
    logic              cap1_hit, cap2_hit;
    logic [CNT_W-1:0]  cnt;
    logic              phase_hi, low_done;

    mtimer16_sync #(.N(N_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({ext_in, cap2_in, cap1_in}),
        .now_o (pin_now),
        .was_o (pin_was)
    );

    always_comb begin
        pin_rise = pin_now & ~pin_was;
        cap_fall = ~pin_now[PIN_CAP2:PIN_CAP1] & pin_was[PIN_CAP2:PIN_CAP1];
        cap_edge = r_q.ctlb[B_POL] ? pin_rise[PIN_CAP2:PIN_CAP1] : cap_fall;
        mode     = mode_e'(r_q.ctlb[1:0]);
        clr_hit  = bus_we && (bus_addr == WR_CLEAR);
        wr_a     = bus_we && (bus_addr == WR_CTLA);
        wr_reg   = bus_we && (bus_addr >= WR_R2_LO) && (bus_addr <= WR_CTLA);
        adv      = (mode == MD_EVENT) ? pin_rise[PIN_EXT] : presc_tick;
        cap1_hit = (mode == MD_CAPT) && cap_edge[PIN_CAP1];
        cap2_hit = (mode == MD_CAPT) && cap_edge[PIN_CAP2];
    end

    mtimer16_presc #(.PS_W(PS_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_hit),
        .ps    (r_q.ctlb[B_PS_LO +: PS_W]),
        .tick  (presc_tick)
    );

    mtimer16_seq #(.W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_hit),
        .adv      (adv),
        .mode     (mode),
        .len_hi   (r_q.r1),
        .len_lo   (r_q.r2),
        .cnt      (cnt),
        .phase_hi (phase_hi),
        .low_done (low_done)
    );

    // register file next state: bus writes first, hardware events on top
    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            case (bus_addr)
                WR_R2_LO: r_d.r2[BYTE_W-1:0]      = bus_wdata;
                WR_R2_HI: r_d.r2[CNT_W-1:BYTE_W]  = bus_wdata;
                WR_R1_LO: r_d.r1[BYTE_W-1:0]      = bus_wdata;
                WR_R1_HI: r_d.r1[CNT_W-1:BYTE_W]  = bus_wdata;
                WR_CTLB:  r_d.ctlb                = bus_wdata & B_KEEP;
                WR_CTLA:  r_d.ctla                = bus_wdata & A_KEEP;
                default: ;
            endcase
        end
        if (cap1_hit) begin
            r_d.cap            = cnt;
            r_d.ctla[A_CAP1_F] = 1'b1;
        end
        if (cap2_hit) begin
            r_d.r2             = cnt;
            r_d.ctla[A_CAP2_F] = 1'b1;
        end
        if (low_done && !clr_hit) r_d.ctla[A_CMP_F] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            RD_CAP_LO: bus_rdata = r_q.cap[BYTE_W-1:0];
            RD_CAP_HI: bus_rdata = r_q.cap[CNT_W-1:BYTE_W];
            RD_R2_LO:  bus_rdata = r_q.r2[BYTE_W-1:0];
            RD_R2_HI:  bus_rdata = r_q.r2[CNT_W-1:BYTE_W];
            RD_R1_LO:  bus_rdata = r_q.r1[BYTE_W-1:0];
            RD_R1_HI:  bus_rdata = r_q.r1[CNT_W-1:BYTE_W];
            RD_CTLB:   bus_rdata = r_q.ctlb;
            RD_CTLA:   bus_rdata = r_q.ctla;
            default:   bus_rdata = '0;
        endcase
        pwm_out = phase_hi && ((mode == MD_PWM) || (mode == MD_EVENT));
        irq     = ((r_q.ctla[A_CAP1_F] || r_q.ctla[A_CAP2_F]) && r_q.ctla[A_CAP_IE])
               || (r_q.ctla[A_CMP_F] && r_q.ctla[A_CMP_IE]);
    end

    p_cap1_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ctla[A_CAP1_F]) |-> ($past(wr_a) || $past(mode == MD_CAPT)));
    p_cmp_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ctla[A_CMP_F]) |-> ($past(wr_a) || ($past(!phase_hi) && phase_hi)));
    p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (r_q.ctla[A_CAP_IE] || r_q.ctla[A_CMP_IE]));
    p_ignore_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !wr_reg && !cap1_hit && !cap2_hit && !low_done) |=> $stable(r_q));
endmodule

// File: tb/test_mtimer16.sv
`timescale 1ns/1ps
module test_mtimer16;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       cap1_in, cap2_in, ext_in;
    logic       pwm_out, irq;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int c      = 0;

    mtimer16 i_mtimer16 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap1_in   (cap1_in),
        .cap2_in   (cap2_in),
        .ext_in    (ext_in),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_pwm(input int ticks, input int h, input int l);
        int he = (h == 0) ? 1 : h;
        int le = (l == 0) ? 1 : l;
        return (ticks % (he + le)) < he;
    endfunction

    // idle, clear, load R1/R2, control A, control B, clear; c = clear edge
    task automatic setup(input int h, input int l, input logic [7:0] a, input logic [7:0] b);
        wr(5'h16, 8'h00);
        wr(5'h10, 8'h00);
        wr(5'h14, h[7:0]);  wr(5'h15, h[15:8]);
        wr(5'h12, l[7:0]);  wr(5'h13, l[15:8]);
        wr(5'h17, a);
        wr(5'h16, b);
        wr(5'h10, 8'h00);
        c = cyc;
    endtask

    task automatic pwm_run(input int h, input int l, input int ps, input int n, input string req);
        setup(h, l, 8'h00, 8'(ps << 2) | 8'h01);
        repeat (n) begin
            @(negedge clk);
            check(pwm_out == exp_pwm((cyc - c) >> ps, h, l), req, pwm_out,
                  exp_pwm((cyc - c) >> ps, h, l));
        end
    endtask

    task automatic cap_test(input int ps, input bit rise);
        logic [7:0] lo, hi, a;
        int t, e;
        setup(1, 1, 8'h20, (rise ? 8'h42 : 8'h02) | 8'(ps << 2));
        wait_n(3 + int'($urandom % 30));
        if (!rise) begin
            cap1_in = 1'b1; cap2_in = 1'b1;       // inactive direction
            wait_n(5);
            rd(5'h07, a);
            check(a == 8'h20, "R8 rising edge ignored in falling polarity", a, 8'h20);
            @(negedge clk); cap1_in = 1'b0; t = cyc;
        end else begin
            @(negedge clk); cap1_in = 1'b1; t = cyc;
        end
        e = ((t + 2 - c) >> ps) & 16'hFFFF;
        wait_n(3);
        rd(5'h00, lo); rd(5'h01, hi);
        check({hi, lo} == 16'(e), "R7 capture pin 1 value", {hi, lo}, e);
        rd(5'h07, a);
        check(a[6] == 1'b1, "R7 capture flag 1", a[6], 1);
        check(irq == 1'b1, "R12 capture irq", irq, 1);
        wait_n(int'($urandom % 20));
        @(negedge clk);
        if (rise) cap2_in = 1'b1; else cap2_in = 1'b0;
        t = cyc;
        e = ((t + 2 - c) >> ps) & 16'hFFFF;
        wait_n(3);
        rd(5'h02, lo); rd(5'h03, hi);
        check({hi, lo} == 16'(e), "R7 capture pin 2 into R2", {hi, lo}, e);
        rd(5'h07, a);
        check(a[7] == 1'b1, "R7 capture flag 2", a[7], 1);
        if (rise) begin
            wr(5'h17, 8'h20);
            @(negedge clk); cap1_in = 1'b0; cap2_in = 1'b0;
            wait_n(5);
            rd(5'h07, a);
            check(a == 8'h20, "R8 falling edge ignored in rising polarity", a, 8'h20);
            check(irq == 1'b0, "R11 flags cleared by write", irq, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        cap1_in = 1'b0; cap2_in = 1'b0; ext_in = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(5'(i), v);
            check(v == 8'h00, "R1 reset register", v, 0);
        end
        check(pwm_out == 1'b0, "R1 reset pwm_out", pwm_out, 0);
        check(irq == 1'b0, "R1 reset irq", irq, 0);

        // R2 register map and masks
        wr(5'h14, 8'h3C); wr(5'h15, 8'hA5);
        wr(5'h12, 8'h34); wr(5'h13, 8'h12);
        rd(5'h04, v); check(v == 8'h3C, "R2 R1 low", v, 8'h3C);
        rd(5'h05, v); check(v == 8'hA5, "R2 R1 high", v, 8'hA5);
        rd(5'h02, v); check(v == 8'h34, "R2 R2 low", v, 8'h34);
        rd(5'h03, v); check(v == 8'h12, "R2 R2 high", v, 8'h12);
        wr(5'h16, 8'hFF);
        rd(5'h06, v); check(v == 8'h5F, "R2 control B mask", v, 8'h5F);
        wr(5'h17, 8'hFF);
        rd(5'h07, v); check(v == 8'hF4, "R2 control A mask", v, 8'hF4);
        check(irq == 1'b1, "R12 all flags enabled", irq, 1);
        rd(5'h08, v); check(v == 8'h00, "R2 unmapped read 0x08", v, 0);
        rd(5'h17, v); check(v == 8'h00, "R2 unmapped read 0x17", v, 0);

        // R11 and R12 flag/enable combinations
        wr(5'h17, 8'h00);
        rd(5'h07, v); check(v == 8'h00, "R11 zero write clears flags", v, 0);
        check(irq == 1'b0, "R12 no flags", irq, 0);
        wr(5'h17, 8'h10); check(irq == 1'b0, "R12 compare flag without enable", irq, 0);
        wr(5'h17, 8'h14); check(irq == 1'b1, "R12 compare flag with enable", irq, 1);
        wr(5'h17, 8'h40); check(irq == 1'b0, "R12 capture flag without enable", irq, 0);
        wr(5'h17, 8'hA0); check(irq == 1'b1, "R12 capture flag 2 with enable", irq, 1);
        wr(5'h17, 8'h24); check(irq == 1'b0, "R12 enables without flags", irq, 0);

        // R3 ignored writes
        wr(5'h04, 8'h77); wr(5'h11, 8'h77); wr(5'h1D, 8'h77); wr(5'h07, 8'h77);
        rd(5'h04, v); check(v == 8'h3C, "R3 R1 low untouched", v, 8'h3C);
        rd(5'h07, v); check(v == 8'h24, "R3 control A untouched", v, 8'h24);
        rd(5'h06, v); check(v == 8'h5F, "R3 control B untouched", v, 8'h5F);

        // R13 idle mode
        setup(2, 2, 8'h20, 8'h40);
        @(negedge clk); cap1_in = 1'b1; cap2_in = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(pwm_out == 1'b0, "R13 idle pwm_out low", pwm_out, 0);
        end
        rd(5'h07, v); check(v == 8'h20, "R13 idle capture ignored", v, 8'h20);
        rd(5'h00, v); check(v == 8'h00, "R13 idle capture reg", v, 0);
        @(negedge clk); cap1_in = 1'b0; cap2_in = 1'b0;
        wait_n(4);

        // R4, R5, R6 directed and random waveforms
        pwm_run(3, 2, 0, 40, "R4 pwm 3/2");
        pwm_run(0, 0, 0, 12, "R4 zero lengths act as one");
        pwm_run(2, 3, 2, 80, "R5 prescale by 4");
        pwm_run(1, 1, 7, 600, "R5 prescale by 128");
        for (int k = 0; k < 6; k++) begin
            int h = int'($urandom % 7);
            int l = int'($urandom % 7);
            int ps = int'($urandom % 4);
            pwm_run(h, l, ps, 100, "R4 R6 random waveform");
        end

        // R10 compare flag timing, PS=0, period 4
        setup(2, 2, 8'h04, 8'h01);
        for (int i = 0; i < 6; i++) begin
            int n;
            rd(5'h07, v);
            n = cyc - c;
            check(v[4] == (n >= 4), "R10 compare flag at low end", v[4], int'(n >= 4));
            check(irq == (n >= 4), "R12 compare irq", irq, int'(n >= 4));
        end

        // R9 event mode with prescaler set that must not matter
        setup(2, 3, 8'h00, 8'h1F);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); ext_in = 1'b1;
            wait_n(2); ext_in = 1'b0;
            wait_n(2);
            check(pwm_out == exp_pwm(i + 1, 2, 3), "R9 event mode waveform",
                  pwm_out, exp_pwm(i + 1, 2, 3));
        end
        rd(5'h07, v); check(v[4] == 1'b1, "R10 compare flag in event mode", v[4], 1);

        // R7, R8 captures
        cap_test(0, 1'b1);
        cap_test(2, 1'b1);
        cap_test(0, 1'b0);
        for (int k = 0; k < 4; k++) cap_test(int'($urandom % 4), k[0]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule